// File: doc/BRIEF.md
# Dual-Rate Fourth-Order Sinc Decimator

This block converts the one-bit output stream of a delta-sigma modulator into 20-bit two's-complement conversion results. A single-cycle enable strobe marks each modulator sample. Each sample is mapped to +1 for a one and to -1 for a zero. The samples pass through four cascaded integrators that run at the modulator rate. At every decimation point, four cascaded comb stages then produce one result. That result is scaled by an arithmetic right shift and clamped to the 20-bit full-scale codes.

A speed select picks one of two decimation ratios: 7680 samples (slow) or 960 samples (fast). These give 10 and 80 results per second when the sample rate is the master clock divided by 64. Because the filter is fourth order, each notch at a multiple of the output rate carries four coincident zeros. The slow rate therefore rejects 50 Hz and 60 Hz at the same time.

Reset or any change of the speed select restarts the filter from a cleared state. A settled flag then stays low until the results are built entirely from post-restart samples.

Top module: `sinc4_decimator`

## Requirements
- R1: While reset is held, and on the first cycle after it, `result` is 0, `valid` is 0 and `settled` is 0.
- R2: A settled result equals `((2*N1 - L) * R^4 / L) >>> S`, where N1/L is the fraction of ones in the stream, R is the active decimation ratio and S = 4*ceil(log2 R) - 20. With this shift, a full-scale stream reaches a magnitude of 810000 before clamping at both rates.
- R3: With `speed`=0, one result is produced every 7680 enabled samples. With `speed`=1, one result is produced every 960 enabled samples.
- R4: Only cycles with `en` high take a sample. On other cycles the filter state does not advance, so the spacing between results scales with the spacing between strobes. `valid` only rises on the cycle after an enabled sample.
- R5: An all-ones stream produces the positive clamp code 0x7FFFF.
- R6: An all-zeros stream produces the negative clamp code 0x80000.
- R7: `valid` is high for exactly one cycle per result, and `result` holds its value between pulses.
- R8: After a restart, `settled` is 0 with each of the first four results and 1 from the fifth result onward. Every result flagged settled meets R2 exactly.
- R9: A change of `speed` is a restart. It discards the current sample and clears the integrators, combs and counters. The first result then arrives after exactly R new-rate enabled samples.
- R10: A zero-mean stream (alternating ones and zeros) gives a settled result of exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Modulator sample strobe, one cycle per sample |
| din | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| speed | input | 1 | Rate select: 0 = ratio 7680, 1 = ratio 960 |
| result | output | 20 | Two's-complement conversion result |
| valid | output | 1 | One-cycle pulse marking a new result |
| settled | output | 1 | High when the current result is fully settled |

## Verification
Embedded assertions check several properties on every cycle:
- the single-cycle width of `valid`, and that it follows an enabled sample;
- the bound on the decimation count, and that the count freezes while `en` is low;
- the holding of `result` between pulses;
- that a restart clears the integrators and drops `settled`, and that `settled` stays high until the next restart.

The bench scenarios alone can show the arithmetic, because it depends on the whole stream history:
- the exact settled values for streams of different density;
- the asymmetric clamp codes;
- the zero result for a balanced stream;
- the result spacing of both ratios, with sparse strobes and across a rate change.

// File: rtl/sinc_pkg.sv
// Shared definitions for the dual-rate sinc decimator.
// Assumes: the speed select is a single bit, where 1 selects the short ratio.
package sinc_pkg;
    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;
endpackage

// File: rtl/sinc_integrator.sv
// Cascade of ORDER integrators running at the modulator rate.
// Assumes: ACC_W is wide enough that the comb differences stay exact under wrap-around.
// Maps a 1 bit to +1 and a 0 bit to -1.
module sinc_integrator #(
    parameter int ACC_W = 53,
    parameter int ORDER = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    din,
    output logic signed [ACC_W-1:0] acc_out
);
    logic signed [ACC_W-1:0] acc [ORDER];
    logic signed [ACC_W-1:0] sample;

    // Bipolar sample: all-ones (-1) or 1 (+1), sign bits built from the inverted input.
    assign sample = {{(ACC_W-1){~din}}, 1'b1};

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        // Each stage accumulates the previous stage's registered value on enabled samples.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                acc[g] <= '0;
            end else if (en) begin
                if (g == 0) acc[g] <= acc[g] + sample;
                else        acc[g] <= acc[g] + acc[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign acc_out = acc[ORDER-1];

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_out == '0)); // R9
endmodule

// File: rtl/sinc_rate_ctrl.sv
// Decimation counter, restart detection and settle tracking.
// Assumes: en is a one-cycle strobe. A speed change is seen as a restart on the first edge
// that samples the new value.
module sinc_rate_ctrl
    import sinc_pkg::*;
#(
    parameter int RATIO_SLOW = 7680,
    parameter int RATIO_FAST = 960,
    parameter int SETTLE_N   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic speed,
    output logic clr,
    output logic tick,
    output logic settled
);
    localparam int CNT_W = $clog2(RATIO_SLOW);
    localparam int SET_W = $clog2(SETTLE_N + 1);

    logic             speed_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic [SET_W-1:0] remain;

    assign clr  = (speed != speed_q);
    assign last = (rate_e'(speed) == RATE_FAST) ? CNT_W'(RATIO_FAST - 1) : CNT_W'(RATIO_SLOW - 1);
    assign tick = en && !clr && (cnt == last);

    // Remember the rate in use, so that a change can be detected.
    always_ff @(posedge clk) begin
        speed_q <= speed;
    end

    // Count enabled samples within one decimation period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (en)        cnt <= tick ? '0 : cnt + 1'b1;
    end

    // Count down the results that are still unsettled after a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            remain  <= SET_W'(SETTLE_N);
            settled <= 1'b0;
        end else if (tick) begin
            settled <= (remain == '0);
            if (remain != '0) remain <= remain - 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt <= last)); // R3
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt)); // R4
    AST_RESTART_UNSETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !settled); // R9
    AST_SETTLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !clr) |=> settled); // R8
endmodule

// File: rtl/sinc_comb.sv
// Comb cascade evaluated once per decimation tick. It scales the difference by the shift
// of the active rate and clamps it to the signed OUT_W range.
// Assumes: the tick never arrives on a restart cycle.
module sinc_comb #(
    parameter int ACC_W      = 53,
    parameter int ORDER      = 4,
    parameter int OUT_W      = 20,
    parameter int SHIFT_SLOW = 32,
    parameter int SHIFT_FAST = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    tick,
    input  logic                    speed,
    input  logic signed [ACC_W-1:0] acc_in,
    output logic        [OUT_W-1:0] result,
    output logic                    valid
);
    localparam logic signed [ACC_W-1:0] POS_FS = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] NEG_FS = -POS_FS - ACC_W'(1);

    logic signed [ACC_W-1:0] dly   [ORDER];
    logic signed [ACC_W-1:0] diff  [ORDER+1];
    logic signed [ACC_W-1:0] scaled;
    logic        [OUT_W-1:0] clamped;

    assign diff[0] = acc_in;

    for (genvar g = 0; g < ORDER; g++) begin : g_comb
        assign diff[g+1] = diff[g] - dly[g];
        // Store each stage input for the next decimation point.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) dly[g] <= '0;
            else if (tick)     dly[g] <= diff[g];
        end
    end

    // Rate-dependent scaling followed by clamping to the asymmetric full-scale codes.
    always_comb begin
        scaled = speed ? (diff[ORDER] >>> SHIFT_FAST) : (diff[ORDER] >>> SHIFT_SLOW);
        if (scaled > POS_FS)      clamped = POS_FS[OUT_W-1:0];
        else if (scaled < NEG_FS) clamped = NEG_FS[OUT_W-1:0];
        else                      clamped = scaled[OUT_W-1:0];
    end

    // Register the result and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= tick;
            if (tick) result <= clamped;
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(result)); // R7
endmodule

// File: rtl/sinc4_decimator.sv
// Top level: dual-rate fourth-order sinc decimator producing clamped OUT_W-bit results.
// Assumes: en marks modulator samples, and speed may change at any time (a change restarts
// the filter).
module sinc4_decimator #(
    parameter int RATIO_SLOW = 7680,
    parameter int RATIO_FAST = 960,
    parameter int ORDER      = 4,
    parameter int OUT_W      = 20,
    parameter int SETTLE_N   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             din,
    input  logic             speed,
    output logic [OUT_W-1:0] result,
    output logic             valid,
    output logic             settled
);
    localparam int ACC_W      = 1 + ORDER * $clog2(RATIO_SLOW);
    localparam int SHIFT_SLOW = ORDER * $clog2(RATIO_SLOW) - OUT_W;
    localparam int SHIFT_FAST = ORDER * $clog2(RATIO_FAST) - OUT_W;

    logic                    clr;
    logic                    tick;
    logic signed [ACC_W-1:0] acc;

    sinc_rate_ctrl #(
        .RATIO_SLOW (RATIO_SLOW),
        .RATIO_FAST (RATIO_FAST),
        .SETTLE_N   (SETTLE_N)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .speed   (speed),
        .clr     (clr),
        .tick    (tick),
        .settled (settled)
    );

    sinc_integrator #(
        .ACC_W (ACC_W),
        .ORDER (ORDER)
    ) u_integ (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (en),
        .din     (din),
        .acc_out (acc)
    );

    sinc_comb #(
        .ACC_W      (ACC_W),
        .ORDER      (ORDER),
        .OUT_W      (OUT_W),
        .SHIFT_SLOW (SHIFT_SLOW),
        .SHIFT_FAST (SHIFT_FAST)
    ) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .tick   (tick),
        .speed  (speed),
        .acc_in (acc),
        .result (result),
        .valid  (valid)
    );

    AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(en)); // R4
endmodule

// File: tb/sim_sinc4_decimator.sv
module sim_sinc4_decimator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        din = 1'b0;
    logic        speed = 1'b1;
    logic [19:0] result;
    logic        valid;
    logic        settled;

    sinc4_decimator u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .din(din), .speed(speed),
        .result(result), .valid(valid), .settled(settled)
    );

    always #4 clk = ~clk;

    typedef struct {
        longint val;
        bit     chk;
        bit     stl;
        longint gap;
        bit     from_mark;
        string  tag;
    } exp_t;

    exp_t   q[$];
    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;
    longint mark = 0;
    longint last_v = 0;
    logic [3:0] pat = 4'b0000;
    int     per = 1;
    int     ph = 0;
    int     idx = 0;
    bit     finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Stimulus: strobe spacing and pattern bits, driven on the falling edge.
    always @(negedge clk) begin
        ph  = (ph + 1) % per;
        en  = (ph == 0);
        din = pat[idx % 4];
        if (en) idx++;
    end

    // Monitor: pop and compare expected results as the design produces them.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(settled == e.stl, {e.tag, " settled flag (R8)"}, settled, e.stl);
                if (e.chk)
                    chk(longint'($signed(result)) == e.val, {e.tag, " value"},
                        longint'($signed(result)), e.val);
                if (e.gap != 0)
                    chk(((e.from_mark ? cyc - mark : cyc - last_v)) == e.gap,
                        {e.tag, " result spacing (R3)"},
                        e.from_mark ? cyc - mark : cyc - last_v, e.gap);
            end
            last_v = cyc;
        end
    end

    // Expected settled value from stream density: (2*ones-4)/4 * R^4 >>> S, then clamped.
    function automatic longint expect_val(input logic [3:0] p, input longint r);
        longint full;
        int     s;
        int     ones;
        ones = $countones(p);
        full = (r * r * r * r) / 4 * (2 * ones - 4);
        s    = 4 * $clog2(r) - 20;
        full = full >>> s;
        if (full > 524287)  full = 524287;
        if (full < -524288) full = -524288;
        return full;
    endfunction

    task automatic run_case(input logic [3:0] p, input bit sp, input int pr, input int nres,
                            input bit by_reset, input string tag);
        longint r;
        longint v;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        pat = p;
        per = pr;
        if (by_reset) begin
            speed = sp;
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
        end else begin
            speed = sp;
        end
        @(posedge clk);
        #1;
        mark = cyc;
        r = sp ? 960 : 7680;
        v = expect_val(p, r);
        for (int k = 0; k < nres; k++) begin
            exp_t e;
            e.val = v;
            e.chk = (k >= 4);
            e.stl = (k >= 4);
            e.tag = tag;
            e.from_mark = (k == 0);
            if (k == 0) e.gap = (!by_reset && pr == 1) ? r : 0;
            else        e.gap = r * pr;
            q.push_back(e);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(result == 20'h0, "R1 reset result", result, 0);
        chk(valid == 1'b0, "R1 reset valid", valid, 0);
        chk(settled == 1'b0, "R1 reset settled", settled, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid == 1'b0 && settled == 1'b0, "R1 first cycle after reset", valid, 0);
        run_case(4'b0111, 1'b1, 1, 7, 1'b1, "R2 fast three-quarter density");
        run_case(4'b1111, 1'b1, 1, 6, 1'b1, "R5 all ones clamp 0x7FFFF");
        run_case(4'b0000, 1'b1, 1, 6, 1'b1, "R6 all zeros clamp 0x80000");
        run_case(4'b0101, 1'b1, 1, 6, 1'b1, "R10 alternating gives zero");
        run_case(4'b0001, 1'b1, 2, 6, 1'b1, "R4 sparse strobe quarter density");
        run_case(4'b0111, 1'b0, 1, 5, 1'b0, "R9 switch to slow rate");
        run_case(4'b1000, 1'b1, 1, 5, 1'b0, "R9 switch back to fast rate");
        while (q.size() > 0) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d pending results", q.size(), 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule